// File: doc/BRIEF.md
# Prioritized Interrupt Claim Controller

This block sits between a set of external interrupt sources and a set of hart contexts. Each source arrives as a one-cycle pending-set pulse from a separate gateway. The block stores a pending flag and a programmable priority for every source, a per-context enable mask and a per-context priority threshold. For every context it drives one registered interrupt request. The request is high while at least one pending source is enabled for that context and has a priority strictly above that context's threshold.

Software services a context through its claim register. A read returns the ID of the best eligible source: highest priority first, and the lowest ID on a tie. The same read clears that source's pending flag and marks the source as in service. While a source is in service, new pulses for it are dropped. Writing the ID back to a claim register releases the source. Source ID 0 means "no interrupt".

Every access carries a mode flag. Supervisor accesses take effect only while a delegation bit is set, and only machine accesses can change that bit.

Top module: `prio_claim_ctrl`

Word addresses: the priority of source k is at k (1..NSRC), the pending vector is at 0x40, the delegation bit is at 0x41 bit 0. For context c, the enable mask is at 0x80+4c, the threshold at 0x81+4c and the claim/complete register at 0x82+4c. In every vector register, bit k stands for source k.

## Requirements
- R1: After reset all priorities, enables, thresholds, pending flags, in-service flags and the delegation bit are zero. Every interrupt output is low and every claim read returns 0.
- R2: A write to address k (1..NSRC) sets the PRIO_W-bit priority of source k and a read returns it. Address 0 reads 0 and writes to it have no effect.
- R3: A pulse on src_set bit k-1 sets the pending flag of source k. The pending register at 0x40 shows source k in bit k.
- R4: The enable mask at 0x80+4c holds bit k for source k. A source affects context c only while its bit is set.
- R5: A source is eligible for context c only when its priority is strictly greater than the threshold at 0x81+4c. Priority 0 never interrupts, and a threshold at the maximum priority holds the output low.
- R6: A read of the claim register 0x82+4c returns the eligible source with the highest priority, taking the lowest ID on a tie. It returns 0 when none is eligible.
- R7: A claim that returns a nonzero ID clears that source's pending flag and marks it in service in the same cycle. A claim that returns 0 changes no state.
- R8: Pending-set pulses for a source in service are dropped. Writing the source's ID to a claim register releases it, and later pulses set its pending flag again.
- R9: A completion write is ignored if the ID is 0, above NSRC, not enabled for the writing context, or not in service.
- R10: Each irq bit is a register. It reflects pending, enable, priority and threshold state one cycle after that state changes.
- R11: With the delegation bit clear, supervisor accesses (bus_smode=1) read 0 and change nothing, including claim side effects. Supervisor accesses to the delegation bit always read 0 and never change it.
- R12: With the delegation bit set, supervisor accesses to all registers other than the delegation bit behave as machine accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_set | input | NSRC | Pending-set pulses, bit k-1 for source k |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_smode | input | 1 | 1 = supervisor access, 0 = machine access |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_en |
| irq | output | NCTX | Registered interrupt request per context |

## Verification
The bench targets equal-priority ties, including the lowest and highest IDs. A design that scans in the wrong direction or uses a non-strict compare returns the wrong ID. It covers a threshold equal to a source's priority; an off-by-one compare would raise the line there. It covers pulses that arrive while a source is held and completions from a context that lacks the enable or that carry an out-of-range ID; a design that gets these wrong re-pends or frees a source early. It covers supervisor claims with delegation clear; a design that leaks the side effect silently loses a pending source. It also checks irq one cycle after an enable write to catch a combinational path or an extra register stage.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] PEND_ADDR  = 8'h40;
    localparam logic [ADDR_W-1:0] DELEG_ADDR = 8'h41;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_PRIO,
        REG_PEND,
        REG_DELEG,
        REG_ENABLE,
        REG_THRESH,
        REG_CLAIM
    } reg_kind_e;

    typedef enum logic {
        MODE_MACHINE = 1'b0,
        MODE_SUPER   = 1'b1
    } mode_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [5:0] idx;   // source ID or context number
    } reg_sel_t;

    // Address decode: priorities at 1..nsrc, globals at 0x40/0x41,
    // per-context block of four words from 0x80.
    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int nsrc, input int nctx);
        reg_sel_t s;
        s.kind = REG_NONE;
        s.idx  = 6'd0;
        if (a[7:6] == 2'b00) begin
            if (a[5:0] != 6'd0 && int'(a[5:0]) <= nsrc) begin
                s.kind = REG_PRIO;
                s.idx  = a[5:0];
            end
        end else if (a == PEND_ADDR) begin
            s.kind = REG_PEND;
        end else if (a == DELEG_ADDR) begin
            s.kind = REG_DELEG;
        end else if (a[7:5] == 3'b100 && int'(a[4:2]) < nctx) begin
            s.idx = {3'b000, a[4:2]};
            case (a[1:0])
                2'd0:    s.kind = REG_ENABLE;
                2'd1:    s.kind = REG_THRESH;
                2'd2:    s.kind = REG_CLAIM;
                default: s.kind = REG_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/pcc_sources.sv
module pcc_sources #(
    parameter int NSRC   = 12,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NSRC:0]               set_in,
    input  logic                        prio_we,
    input  logic [ID_W-1:0]             prio_idx,
    input  logic [PRIO_W-1:0]           prio_wdata,
    input  logic                        take_valid,
    input  logic [ID_W-1:0]             take_id,
    input  logic                        free_valid,
    input  logic [ID_W-1:0]             free_id,
    output logic [NSRC:0]               pend,
    output logic [NSRC:0]               held,
    output logic [NSRC:0][PRIO_W-1:0]   prio
);

    for (genvar i = 0; i <= NSRC; i++) begin : g_src
        if (i == 0) begin : g_null
            // ID 0 is reserved: never pending, never held, priority 0
            assign pend[0] = 1'b0;
            assign held[0] = 1'b0;
            assign prio[0] = '0;
        end else begin : g_real
            logic              pend_q;
            logic              held_q;
            logic [PRIO_W-1:0] prio_q;
            wire               hit_take = take_valid && (take_id == ID_W'(i));
            wire               hit_free = free_valid && (free_id == ID_W'(i));

            always_ff @(posedge clk) begin
                if (rst) begin
                    pend_q <= 1'b0;
                    held_q <= 1'b0;
                    prio_q <= '0;
                end else begin
                    if (prio_we && prio_idx == ID_W'(i))
                        prio_q <= prio_wdata;
                    if (hit_take)
                        pend_q <= 1'b0;
                    else if (set_in[i] && !held_q)
                        pend_q <= 1'b1;
                    if (hit_take)
                        held_q <= 1'b1;
                    else if (hit_free)
                        held_q <= 1'b0;
                end
            end

            assign pend[i] = pend_q;
            assign held[i] = held_q;
            assign prio[i] = prio_q;
        end
    end

endmodule

// File: rtl/pcc_arbiter.sv
module pcc_arbiter #(
    parameter int NSRC   = 12,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 4
) (
    input  logic [NSRC:0]             pend,
    input  logic [NSRC:0]             en,
    input  logic [NSRC:0][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]         thr,
    output logic [ID_W-1:0]           win_id
);

    logic [PRIO_W-1:0] best_p;

    // Ascending scan with a strict compare: the first source seen at the
    // top priority keeps the slot, so the lowest ID wins a tie.
    always_comb begin
        best_p = thr;
        win_id = '0;
        for (int i = 0; i <= NSRC; i++) begin
            if (pend[i] && en[i] && prio[i] > best_p) begin
                best_p = prio[i];
                win_id = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/pcc_context.sv
module pcc_context #(
    parameter int NSRC   = 12,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en_we,
    input  logic [NSRC:1]             en_wdata,
    input  logic                      thr_we,
    input  logic [PRIO_W-1:0]         thr_wdata,
    input  logic [NSRC:0]             pend,
    input  logic [NSRC:0][PRIO_W-1:0] prio,
    output logic [NSRC:0]             en_q,
    output logic [PRIO_W-1:0]         thr_q,
    output logic [ID_W-1:0]           win_id,
    output logic                      irq_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            thr_q <= '0;
            irq_q <= 1'b0;
        end else begin
            if (en_we)
                en_q <= {en_wdata, 1'b0};
            if (thr_we)
                thr_q <= thr_wdata;
            irq_q <= (win_id != '0);
        end
    end

    pcc_arbiter #(
        .NSRC   (NSRC),
        .PRIO_W (PRIO_W),
        .ID_W   (ID_W)
    ) u_arb (
        .pend   (pend),
        .en     (en_q),
        .prio   (prio),
        .thr    (thr_q),
        .win_id (win_id)
    );

endmodule

// File: rtl/prio_claim_ctrl.sv
module prio_claim_ctrl
    import pcc_pkg::*;
#(
    parameter int NSRC   = 12,   // at most 31
    parameter int NCTX   = 3,    // at most 8
    parameter int PRIO_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_set,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic              bus_smode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCTX-1:0]   irq
);

    localparam int ID_W  = $clog2(NSRC + 1);
    localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1;

    reg_sel_t sel;
    mode_e    mode;
    logic     deleg_q;
    logic     granted;
    logic     wr;
    logic     rd;
    logic [CTX_W-1:0] ctx_idx;

    logic [NSRC:0]               pend_w;
    logic [NSRC:0]               held_w;
    logic [NSRC:0][PRIO_W-1:0]   prio_w;
    logic [NCTX-1:0][NSRC:0]     en_arr;
    logic [NCTX-1:0][PRIO_W-1:0] thr_arr;
    logic [NCTX-1:0][ID_W-1:0]   win_arr;

    logic            take_valid;
    logic [ID_W-1:0] take_id;
    logic            free_valid;
    logic [ID_W-1:0] free_id;
    logic            id_ok;

    assign sel     = decode_addr(bus_addr, NSRC, NCTX);
    assign mode    = mode_e'(bus_smode);
    assign ctx_idx = sel.idx[CTX_W-1:0];
    assign granted = bus_en &&
                     (mode == MODE_MACHINE || (deleg_q && sel.kind != REG_DELEG));
    assign wr      = granted && bus_we;
    assign rd      = granted && !bus_we;

    always_ff @(posedge clk) begin
        if (rst)
            deleg_q <= 1'b0;
        else if (wr && sel.kind == REG_DELEG)
            deleg_q <= bus_wdata[0];
    end

    // Claim: the read itself takes the winning source.
    assign take_id    = win_arr[ctx_idx];
    assign take_valid = rd && sel.kind == REG_CLAIM && take_id != '0;

    // Completion: ID must be a real source, enabled here and held.
    assign free_id    = bus_wdata[ID_W-1:0];
    assign id_ok      = (bus_wdata <= DATA_W'(NSRC)) && (free_id != '0);
    assign free_valid = wr && sel.kind == REG_CLAIM && id_ok &&
                        en_arr[ctx_idx][free_id] && held_w[free_id];

    pcc_sources #(
        .NSRC   (NSRC),
        .PRIO_W (PRIO_W),
        .ID_W   (ID_W)
    ) u_src (
        .clk        (clk),
        .rst        (rst),
        .set_in     ({src_set, 1'b0}),
        .prio_we    (wr && sel.kind == REG_PRIO),
        .prio_idx   (sel.idx[ID_W-1:0]),
        .prio_wdata (bus_wdata[PRIO_W-1:0]),
        .take_valid (take_valid),
        .take_id    (take_id),
        .free_valid (free_valid),
        .free_id    (free_id),
        .pend       (pend_w),
        .held       (held_w),
        .prio       (prio_w)
    );

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        pcc_context #(
            .NSRC   (NSRC),
            .PRIO_W (PRIO_W),
            .ID_W   (ID_W)
        ) u_ctx (
            .clk       (clk),
            .rst       (rst),
            .en_we     (wr && sel.kind == REG_ENABLE && ctx_idx == CTX_W'(c)),
            .en_wdata  (bus_wdata[NSRC:1]),
            .thr_we    (wr && sel.kind == REG_THRESH && ctx_idx == CTX_W'(c)),
            .thr_wdata (bus_wdata[PRIO_W-1:0]),
            .pend      (pend_w),
            .prio      (prio_w),
            .en_q      (en_arr[c]),
            .thr_q     (thr_arr[c]),
            .win_id    (win_arr[c]),
            .irq_q     (irq[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            unique case (sel.kind)
                REG_PRIO:   bus_rdata = DATA_W'(prio_w[sel.idx]);
                REG_PEND:   bus_rdata = DATA_W'(pend_w);
                REG_DELEG:  bus_rdata = DATA_W'(deleg_q);
                REG_ENABLE: bus_rdata = DATA_W'(en_arr[ctx_idx]);
                REG_THRESH: bus_rdata = DATA_W'(thr_arr[ctx_idx]);
                REG_CLAIM:  bus_rdata = DATA_W'(take_id);
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/pcc_checker.sv
module pcc_checker
    import pcc_pkg::*;
#(
    parameter int NSRC   = 12,
    parameter int NCTX   = 3,
    parameter int PRIO_W = 3
) (
    input logic                        clk,
    input logic                        rst,
    input logic [NSRC-1:0]             src_set,
    input logic                        bus_en,
    input logic                        bus_we,
    input logic                        bus_smode,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [DATA_W-1:0]           bus_rdata,
    input logic [NCTX-1:0]             irq,
    input logic                        deleg,
    input logic [NSRC:0]               pend,
    input logic [NSRC:0]               held,
    input logic [NCTX-1:0][PRIO_W-1:0] thr
);

    localparam int ID_W = $clog2(NSRC + 1);

    wire claim_rd = bus_en && !bus_we && (!bus_smode || deleg) &&
                    bus_addr[7:5] == 3'b100 && bus_addr[1:0] == 2'b10 &&
                    int'(bus_addr[4:2]) < NCTX;

    AST_SUPV_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_smode && !deleg && !bus_we) |-> bus_rdata == '0); // R11

    AST_SUPV_DELEG_LOCK: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_smode && bus_we && bus_addr == DELEG_ADDR) |=> $stable(deleg)); // R11

    AST_CLAIM_TAKES: assert property (@(posedge clk) disable iff (rst)
        (claim_rd && bus_rdata != '0) |=>
            (held[$past(bus_rdata[ID_W-1:0])] && !pend[$past(bus_rdata[ID_W-1:0])])); // R7

    AST_EMPTY_CLAIM_NOP: assert property (@(posedge clk) disable iff (rst)
        (claim_rd && bus_rdata == '0 && src_set == '0) |=>
            ($stable(pend) && $stable(held))); // R7

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx_chk
        AST_THR_MAX_QUIET: assert property (@(posedge clk) disable iff (rst)
            ($past(thr[c]) == {PRIO_W{1'b1}}) |-> !irq[c]); // R5
    end

    for (genvar i = 1; i <= NSRC; i++) begin : g_src_chk
        AST_HELD_NO_REPEND: assert property (@(posedge clk) disable iff (rst)
            (held[i] && !pend[i]) |=> !pend[i]); // R8
    end

endmodule

bind prio_claim_ctrl pcc_checker #(
    .NSRC   (NSRC),
    .NCTX   (NCTX),
    .PRIO_W (PRIO_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_set   (src_set),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_smode (bus_smode),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .deleg     (deleg_q),
    .pend      (pend_w),
    .held      (held_w),
    .thr       (thr_arr)
);

// File: tb/prio_claim_ctrl_bench.sv
module prio_claim_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC   = 12;
    localparam int NCTX   = 3;
    localparam int PRIO_W = 3;

    localparam logic [2:0] OP_WR   = 3'd0;  // bus write
    localparam logic [2:0] OP_RD   = 3'd1;  // bus read, compare
    localparam logic [2:0] OP_PLS  = 3'd2;  // one-cycle src_set pulse
    localparam logic [2:0] OP_IRQ  = 3'd3;  // compare irq after next edge
    localparam logic [2:0] OP_NOW  = 3'd4;  // compare irq immediately

    typedef struct packed {
        logic [2:0]  op;
        logic        sm;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] expv;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 48;
    localparam vec_t VECS [NVEC] = '{
        '{OP_RD,  1'b0, 8'h40, 32'h0,    32'h0,    4'd1},  // R1 pending clear
        '{OP_RD,  1'b0, 8'h80, 32'h0,    32'h0,    4'd1},  // R1 enables clear
        '{OP_RD,  1'b0, 8'h82, 32'h0,    32'h0,    4'd1},  // R1 claim empty
        '{OP_NOW, 1'b0, 8'h00, 32'h0,    32'h0,    4'd1},  // R1 irq low
        '{OP_WR,  1'b0, 8'h03, 32'h5,    32'h0,    4'd2},
        '{OP_RD,  1'b0, 8'h03, 32'h0,    32'h5,    4'd2},  // R2 readback
        '{OP_WR,  1'b0, 8'h00, 32'h7,    32'h0,    4'd2},
        '{OP_RD,  1'b0, 8'h00, 32'h0,    32'h0,    4'd2},  // R2 address 0
        '{OP_WR,  1'b0, 8'h05, 32'h5,    32'h0,    4'd2},
        '{OP_WR,  1'b0, 8'h07, 32'h6,    32'h0,    4'd2},
        '{OP_PLS, 1'b0, 8'h00, 32'h16,   32'h0,    4'd3},  // ids 2,3,5
        '{OP_RD,  1'b0, 8'h40, 32'h0,    32'h2C,   4'd3},  // R3
        '{OP_IRQ, 1'b0, 8'h00, 32'h0,    32'h0,    4'd4},  // R4 no enables
        '{OP_WR,  1'b0, 8'h80, 32'hAC,   32'h0,    4'd4},  // ids 2,3,5,7
        '{OP_NOW, 1'b0, 8'h00, 32'h0,    32'h0,    4'd10}, // R10 not yet
        '{OP_IRQ, 1'b0, 8'h00, 32'h0,    32'h1,    4'd10}, // R10 one cycle on
        '{OP_WR,  1'b0, 8'h81, 32'h5,    32'h0,    4'd5},
        '{OP_IRQ, 1'b0, 8'h00, 32'h0,    32'h0,    4'd5},  // R5 equal not enough
        '{OP_WR,  1'b0, 8'h81, 32'h4,    32'h0,    4'd5},
        '{OP_RD,  1'b0, 8'h81, 32'h0,    32'h4,    4'd5},  // R5 readback
        '{OP_IRQ, 1'b0, 8'h00, 32'h0,    32'h1,    4'd5},  // R5
        '{OP_RD,  1'b0, 8'h82, 32'h0,    32'h3,    4'd6},  // R6 tie 3 vs 5
        '{OP_RD,  1'b0, 8'h40, 32'h0,    32'h24,   4'd7},  // R7 id 3 cleared
        '{OP_PLS, 1'b0, 8'h00, 32'h4,    32'h0,    4'd8},
        '{OP_RD,  1'b0, 8'h40, 32'h0,    32'h24,   4'd8},  // R8 held drops pulse
        '{OP_WR,  1'b0, 8'h86, 32'h3,    32'h0,    4'd9},  // ctx1 lacks enable
        '{OP_PLS, 1'b0, 8'h00, 32'h4,    32'h0,    4'd9},
        '{OP_RD,  1'b0, 8'h40, 32'h0,    32'h24,   4'd9},  // R9 still held
        '{OP_WR,  1'b0, 8'h82, 32'h3,    32'h0,    4'd8},  // release
        '{OP_PLS, 1'b0, 8'h00, 32'h4,    32'h0,    4'd8},
        '{OP_RD,  1'b0, 8'h40, 32'h0,    32'h2C,   4'd8},  // R8 re-pended
        '{OP_RD,  1'b0, 8'h82, 32'h0,    32'h3,    4'd6},  // R6
        '{OP_RD,  1'b0, 8'h82, 32'h0,    32'h5,    4'd6},  // R6
        '{OP_RD,  1'b0, 8'h82, 32'h0,    32'h0,    4'd7},  // R7 only prio 0 left
        '{OP_RD,  1'b0, 8'h40, 32'h0,    32'h4,    4'd7},  // R7 unchanged
        '{OP_IRQ, 1'b0, 8'h00, 32'h0,    32'h0,    4'd5},  // R5 prio 0 silent
        '{OP_WR,  1'b1, 8'h04, 32'h6,    32'h0,    4'd11},
        '{OP_RD,  1'b0, 8'h04, 32'h0,    32'h0,    4'd11}, // R11 write dropped
        '{OP_RD,  1'b1, 8'h40, 32'h0,    32'h0,    4'd11}, // R11 reads zero
        '{OP_WR,  1'b1, 8'h41, 32'h1,    32'h0,    4'd11},
        '{OP_RD,  1'b0, 8'h41, 32'h0,    32'h0,    4'd11}, // R11 bit locked
        '{OP_WR,  1'b0, 8'h41, 32'h1,    32'h0,    4'd12},
        '{OP_RD,  1'b0, 8'h41, 32'h0,    32'h1,    4'd12}, // R12
        '{OP_RD,  1'b1, 8'h41, 32'h0,    32'h0,    4'd11}, // R11 bit hidden
        '{OP_RD,  1'b1, 8'h40, 32'h0,    32'h4,    4'd12}, // R12
        '{OP_WR,  1'b1, 8'h04, 32'h6,    32'h0,    4'd12},
        '{OP_RD,  1'b1, 8'h04, 32'h0,    32'h6,    4'd12}, // R12
        '{OP_RD,  1'b0, 8'h04, 32'h0,    32'h6,    4'd12}  // R12
    };

    logic            clk = 1'b0;
    logic            rst;
    logic [NSRC-1:0] src_set;
    logic            bus_en;
    logic            bus_we;
    logic            bus_smode;
    logic [7:0]      bus_addr;
    logic [31:0]     bus_wdata;
    logic [31:0]     bus_rdata;
    logic [NCTX-1:0] irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prio_claim_ctrl #(
        .NSRC   (NSRC),
        .NCTX   (NCTX),
        .PRIO_W (PRIO_W)
    ) u_prio_claim_ctrl (
        .clk       (clk),
        .rst       (rst),
        .src_set   (src_set),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_smode (bus_smode),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input int req, input string what,
                         input logic [31:0] got, input logic [31:0] expv);
        n_checks++;
        if (got !== expv) begin
            n_fails++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, got, expv);
        end
    endtask

    task automatic access(input logic sm, input logic we, input logic [7:0] addr,
                          input logic [31:0] wdata, output logic [31:0] rdata);
        @(negedge clk);
        bus_en    = 1'b1;
        bus_we    = we;
        bus_smode = sm;
        bus_addr  = addr;
        bus_wdata = wdata;
        #1;
        rdata = bus_rdata;
        @(posedge clk);
        #1;
        bus_en = 1'b0;
        bus_we = 1'b0;
    endtask

    task automatic pulse(input logic [NSRC-1:0] v);
        @(negedge clk);
        src_set = v;
        @(posedge clk);
        #1;
        src_set = '0;
    endtask

    task automatic wr(input logic sm, input logic [7:0] a, input logic [31:0] d);
        logic [31:0] dummy;
        access(sm, 1'b1, a, d, dummy);
    endtask

    task automatic rd_chk(input int req, input logic sm, input logic [7:0] a,
                          input logic [31:0] expv);
        logic [31:0] got;
        access(sm, 1'b0, a, 32'h0, got);
        check(req, $sformatf("read %h", a), got, expv);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst       = 1'b1;
        src_set   = '0;
        bus_en    = 1'b0;
        bus_we    = 1'b0;
        bus_smode = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        for (int k = 0; k < NVEC; k++) begin
            case (VECS[k].op)
                OP_WR:  wr(VECS[k].sm, VECS[k].addr, VECS[k].data);
                OP_RD:  rd_chk(int'(VECS[k].req), VECS[k].sm, VECS[k].addr, VECS[k].expv);
                OP_PLS: pulse(VECS[k].data[NSRC-1:0]);
                OP_IRQ: begin
                    @(posedge clk);
                    #1;
                    check(int'(VECS[k].req), "irq", 32'(irq), VECS[k].expv);
                end
                default: begin
                    #1;
                    check(int'(VECS[k].req), "irq now", 32'(irq), VECS[k].expv);
                end
            endcase
        end

        // R1: mid-run reset returns everything to zero
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(1, "irq after reset", 32'(irq), 32'h0);
        rd_chk(1, 1'b0, 8'h40, 32'h0);
        rd_chk(1, 1'b0, 8'h41, 32'h0);
        rd_chk(1, 1'b0, 8'h04, 32'h0);

        // R11: supervisor claim without delegation takes nothing
        wr(1'b0, 8'h01, 32'h7);
        wr(1'b0, 8'h0C, 32'h7);
        wr(1'b0, 8'h84, 32'h1002);       // ctx1 enables ids 1 and 12
        pulse(12'h801);
        rd_chk(11, 1'b1, 8'h86, 32'h0);
        rd_chk(11, 1'b0, 8'h40, 32'h1002);
        check(4, "irq ctx1 only", 32'(irq), 32'h2);   // R4

        // R6: tie at both ends of the ID range
        rd_chk(6, 1'b0, 8'h86, 32'h1);
        rd_chk(6, 1'b0, 8'h86, 32'hC);
        rd_chk(6, 1'b0, 8'h86, 32'h0);
        @(posedge clk);
        #1;
        check(10, "irq after drain", 32'(irq), 32'h0);  // R10

        // R9: completion from a context without the enable
        wr(1'b0, 8'h8A, 32'h1);
        pulse(12'h001);
        rd_chk(9, 1'b0, 8'h40, 32'h0);
        // R9: out-of-range ID with a valid low part
        wr(1'b0, 8'h86, 32'h100C);
        pulse(12'h800);
        rd_chk(9, 1'b0, 8'h40, 32'h0);
        // R8: proper release from the owning context
        wr(1'b0, 8'h86, 32'h1);
        pulse(12'h001);
        rd_chk(8, 1'b0, 8'h40, 32'h2);

        finish_run();
    end

endmodule